// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block takes a processor into a trap. When a trap request arrives, it decides which privilege level handles the trap: supervisor (S) or machine (M). It then updates that level's status bits and its cause, exception-pc and trap-value registers in one clock cycle. In the same cycle it produces the handler address, the new privilege and a pulse that clears the load reservation. A request carries:
- an asynchronous flag (set for interrupts);
- a cause number;
- the faulting address;
- the current pc;
- the current privilege.

The block holds the registers it needs:
- the interrupt-enable status bits and their saved copies;
- the saved previous-privilege fields;
- one delegation mask for exceptions and one for interrupts;
- one trap-vector register for S and one for M;
- the per-level cause, epc and tval registers.

A narrow configuration write port loads these registers. Through it, the surrounding control-register file writes the status, delegation and vector values. All trap-side state is visible on output ports. Return from trap and control-register decoding belong to other blocks.

Privilege is encoded U=0, S=1, M=3. The status word places its fields at fixed bit positions:

| Bit(s) | Field |
|--------|-------|
| 1 | S interrupt enable |
| 3 | M interrupt enable |
| 5 | saved S enable |
| 7 | saved M enable |
| 8 | S previous privilege |
| 12:11 | M previous privilege |

Configuration select codes on `cfg_sel`:

| Code | Register written |
|------|------------------|
| 0 | status |
| 1 | exception delegation |
| 2 | interrupt delegation |
| 3 | S vector |
| 4 | M vector |

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask is the interrupt delegation register when `trap_async`=1, and the exception delegation register otherwise. The mask is indexed by the effective cause.
- R2: A trap is handled at S (new privilege 1) only when the current privilege is 0 or 1 and the selected mask bit is set. Otherwise it is handled at M (new privilege 3).
- R3: On an S entry, the following registers are updated at the next clock edge, and the M registers are left unchanged:
  - saved S enable (bit 5) takes the S enable;
  - S previous privilege (bit 8) takes bit 0 of the old privilege;
  - S enable (bit 1) is cleared;
  - sepc takes `trap_pc`;
  - scause takes the effective cause, with `trap_async` in bit XLEN-1.
- R4: On an M entry, the following registers are updated at the next clock edge:
  - saved M enable (bit 7) takes the M enable;
  - M previous privilege (bits 12:11) takes the old privilege;
  - M enable (bit 3) is cleared;
  - mepc takes `trap_pc`;
  - mcause takes the effective cause, with `trap_async` in bit XLEN-1.
- R5: `new_pc` is the handling level's vector with bits 1:0 cleared. When `trap_async`=1 and vector bits 1:0 equal 01, the pc is offset by 4 times the cause. In all other cases there is no offset.
- R6: The tval register of the handling level takes `trap_addr` only for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13, 15, 20, 21 and 23. For every other trap it takes zero.
- R7: A synchronous cause 8 is replaced by 8 plus the current privilege (9 from S, 11 from M) before delegation and recording.
- R8: `resv_clear` is high exactly in cycles where `trap_valid` is high.
- R9: With `trap_valid` and `cfg_we` low, every register output holds its value.
- R10: When `trap_valid` is low, a configuration write with `cfg_we`=1 loads the register chosen by `cfg_sel` at the next edge. The write is visible on `status_out` for code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request, committed this cycle |
| trap_async | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | CAUSE_W | Raw cause number |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | pc of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | XLEN | Configuration write data |
| new_pc | output | XLEN | Handler address (valid with trap_valid) |
| new_priv | output | 2 | Handling privilege (valid with trap_valid) |
| resv_clear | output | 1 | Clear load reservation |
| status_out | output | XLEN | Status word |
| scause_out | output | XLEN | S cause |
| sepc_out | output | XLEN | S exception pc |
| stval_out | output | XLEN | S trap value |
| mcause_out | output | XLEN | M cause |
| mepc_out | output | XLEN | M exception pc |
| mtval_out | output | XLEN | M trap value |

## Verification
The hardest case to reach is a single cause number whose delegation differs between the interrupt mask and the exception mask. Only such a cause reveals which mask was read. The bench loads the two masks with deliberately different bit patterns: bit 2 is set only for exceptions, and bit 5 is set only for interrupts. It then raises cause 2 asynchronously from S, expecting M handling. It also raises cause 2 synchronously from M, which must stay at M despite the set bit. Ecall remapping is driven the same way: exception bit 8 is delegated and bit 9 is not, so the remapped cause, not the raw cause, must select the level.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [1:0]         cur_priv,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [XLEN-1:0]    cfg_wdata,
  output logic [XLEN-1:0]    new_pc,
  output logic [1:0]         new_priv,
  output logic               resv_clear,
  output logic [XLEN-1:0]    status_out,
  output logic [XLEN-1:0]    scause_out,
  output logic [XLEN-1:0]    sepc_out,
  output logic [XLEN-1:0]    stval_out,
  output logic [XLEN-1:0]    mcause_out,
  output logic [XLEN-1:0]    mepc_out,
  output logic [XLEN-1:0]    mtval_out
);

  localparam logic [1:0]         PRIV_S     = 2'd1;
  localparam logic [1:0]         PRIV_M     = 2'd3;
  localparam logic [CAUSE_W-1:0] ECALL_BASE = CAUSE_W'(8);

  logic            sie_q, mie_q, spie_q, mpie_q, spp_q;
  logic [1:0]      mpp_q;
  logic [XLEN-1:0] medeleg_q, mideleg_q, stvec_q, mtvec_q;
  logic [XLEN-1:0] scause_q, sepc_q, stval_q, mcause_q, mepc_q, mtval_q;

  function automatic logic carries_addr(input logic [CAUSE_W-1:0] c);
    return int'(c) inside {0, 1, 4, 5, 6, 7, 12, 13, 15, 20, 21, 23};
  endfunction

  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    deleg_vec, tvec_sel, vec_off, cause_val, tval_val;
  logic               to_s;

  assign eff_cause = (!trap_async && trap_cause == ECALL_BASE)
                   ? ECALL_BASE + CAUSE_W'(cur_priv) : trap_cause;
  assign deleg_vec = trap_async ? mideleg_q : medeleg_q;
  assign to_s      = (cur_priv <= PRIV_S) && deleg_vec[eff_cause];
  assign tvec_sel  = to_s ? stvec_q : mtvec_q;
  assign vec_off   = (trap_async && tvec_sel[1:0] == 2'b01)
                   ? (XLEN'(eff_cause) << 2) : '0;
  assign new_pc    = {tvec_sel[XLEN-1:2], 2'b00} + vec_off;
  assign new_priv  = to_s ? PRIV_S : PRIV_M;
  assign tval_val  = (!trap_async && carries_addr(eff_cause)) ? trap_addr : '0;
  assign resv_clear = trap_valid;

  always_comb begin
    cause_val = '0;
    cause_val[XLEN-1] = trap_async;
    cause_val[CAUSE_W-1:0] = eff_cause;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sie_q <= 1'b0; mie_q <= 1'b0; spie_q <= 1'b0; mpie_q <= 1'b0;
      spp_q <= 1'b0; mpp_q <= 2'b00;
      medeleg_q <= '0; mideleg_q <= '0; stvec_q <= '0; mtvec_q <= '0;
      scause_q <= '0; sepc_q <= '0; stval_q <= '0;
      mcause_q <= '0; mepc_q <= '0; mtval_q <= '0;
    end else if (trap_valid) begin
      if (to_s) begin
        spie_q   <= sie_q;
        spp_q    <= cur_priv[0];
        sie_q    <= 1'b0;
        scause_q <= cause_val;
        sepc_q   <= trap_pc;
        stval_q  <= tval_val;
      end else begin
        mpie_q   <= mie_q;
        mpp_q    <= cur_priv;
        mie_q    <= 1'b0;
        mcause_q <= cause_val;
        mepc_q   <= trap_pc;
        mtval_q  <= tval_val;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin
          sie_q  <= cfg_wdata[1];
          mie_q  <= cfg_wdata[3];
          spie_q <= cfg_wdata[5];
          mpie_q <= cfg_wdata[7];
          spp_q  <= cfg_wdata[8];
          mpp_q  <= cfg_wdata[12:11];
        end
        3'd1: medeleg_q <= cfg_wdata;
        3'd2: mideleg_q <= cfg_wdata;
        3'd3: stvec_q   <= cfg_wdata;
        3'd4: mtvec_q   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    status_out = '0;
    status_out[1]     = sie_q;
    status_out[3]     = mie_q;
    status_out[5]     = spie_q;
    status_out[7]     = mpie_q;
    status_out[8]     = spp_q;
    status_out[12:11] = mpp_q;
  end

  assign scause_out = scause_q;
  assign sepc_out   = sepc_q;
  assign stval_out  = stval_q;
  assign mcause_out = mcause_q;
  assign mepc_out   = mepc_q;
  assign mtval_out  = mtval_q;

  a_r2_m_stays_m: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && cur_priv == PRIV_M |-> new_priv == PRIV_M);

  a_r3_s_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && new_priv == PRIV_S |=>
      !status_out[1] && status_out[5] == $past(status_out[1]) &&
      sepc_out == $past(trap_pc) && $stable(mepc_out));

  a_r4_m_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && new_priv == PRIV_M |=>
      !status_out[3] && status_out[7] == $past(status_out[3]) &&
      status_out[12:11] == $past(cur_priv) && mepc_out == $past(trap_pc));

  a_r5_aligned_pc: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !trap_async |-> new_pc[1:0] == 2'b00);

  a_r6_async_no_tval: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && trap_async && new_priv == PRIV_M |=> mtval_out == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid && !cfg_we |=> $stable(mepc_out) && $stable(sepc_out) &&
      $stable(status_out) && $stable(mcause_out) && $stable(scause_out));

endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 1'b0, trap_async = 1'b0;
  logic [4:0] trap_cause = '0;
  logic [31:0] trap_addr = '0, trap_pc = '0;
  logic [1:0] cur_priv = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] new_pc, status_out, scause_out, sepc_out, stval_out;
  logic [31:0] mcause_out, mepc_out, mtval_out;
  logic [1:0] new_priv;
  logic resv_clear;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] cap_pc;
  logic [1:0]  cap_priv;
  logic        cap_resv;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
    .trap_cause(trap_cause), .trap_addr(trap_addr), .trap_pc(trap_pc),
    .cur_priv(cur_priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .new_pc(new_pc), .new_priv(new_priv), .resv_clear(resv_clear),
    .status_out(status_out), .scause_out(scause_out), .sepc_out(sepc_out),
    .stval_out(stval_out), .mcause_out(mcause_out), .mepc_out(mepc_out),
    .mtval_out(mtval_out));

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic raise(input logic async, input logic [4:0] cause,
                       input logic [31:0] addr, input logic [31:0] pc,
                       input logic [1:0] priv);
    @(negedge clk);
    trap_valid = 1'b1; trap_async = async; trap_cause = cause;
    trap_addr = addr; trap_pc = pc; cur_priv = priv;
    #1;
    cap_pc = new_pc; cap_priv = new_priv; cap_resv = resv_clear;
    @(negedge clk);
    trap_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R9", "status after reset", status_out, 32'h0);
    chk("R9", "mepc after reset", mepc_out, 32'h0);
    chk("R8", "resv_clear idle", {31'b0, resv_clear}, 32'h0);
  endtask

  task automatic t_setup;
    cfg_write(3'd0, 32'h0000_000A);
    #1 chk("R10", "status write", status_out, 32'h0000_000A);
    cfg_write(3'd1, (32'h1 << 2) | (32'h1 << 8) | (32'h1 << 13));
    cfg_write(3'd2, 32'h1 << 5);
    cfg_write(3'd3, 32'h0000_2001);
    cfg_write(3'd4, 32'h0000_1000);
  endtask

  task automatic t_sync_to_s;
    raise(1'b0, 5'd13, 32'hDEAD_0000, 32'h0000_0400, 2'd0);
    chk("R2", "priv delegated page fault", {30'b0, cap_priv}, 32'd1);
    chk("R5", "pc sync vectored S", cap_pc, 32'h0000_2000);
    chk("R8", "resv_clear on trap", {31'b0, cap_resv}, 32'd1);
    chk("R3", "scause", scause_out, 32'd13);
    chk("R3", "sepc", sepc_out, 32'h0000_0400);
    chk("R6", "stval page fault", stval_out, 32'hDEAD_0000);
    chk("R3", "status after S entry", status_out, 32'h0000_0028);
    chk("R3", "mepc untouched", mepc_out, 32'h0);
  endtask

  task automatic t_async_to_s;
    raise(1'b1, 5'd5, 32'h1234_5678, 32'h0000_0500, 2'd1);
    chk("R1", "async cause 5 via interrupt mask", {30'b0, cap_priv}, 32'd1);
    chk("R5", "vectored offset", cap_pc, 32'h0000_2014);
    chk("R3", "scause async msb", scause_out, 32'h8000_0005);
    chk("R6", "stval zero for interrupt", stval_out, 32'h0);
    chk("R3", "status spp", status_out, 32'h0000_0108);
  endtask

  task automatic t_mask_split;
    raise(1'b1, 5'd2, 32'hAAAA_0000, 32'h0000_0600, 2'd1);
    chk("R1", "async cause 2 not delegated", {30'b0, cap_priv}, 32'd3);
    chk("R5", "direct M vector", cap_pc, 32'h0000_1000);
    chk("R4", "mcause", mcause_out, 32'h8000_0002);
    chk("R4", "mepc", mepc_out, 32'h0000_0600);
    chk("R6", "mtval async", mtval_out, 32'h0);
    chk("R4", "status M entry", status_out, 32'h0000_0980);
  endtask

  task automatic t_from_m;
    raise(1'b0, 5'd2, 32'hBBBB_0000, 32'h0000_0700, 2'd3);
    chk("R2", "M priv ignores delegation", {30'b0, cap_priv}, 32'd3);
    chk("R6", "mtval illegal instr", mtval_out, 32'h0);
    chk("R4", "status mpp=3", status_out, 32'h0000_1900);
  endtask

  task automatic t_ecall;
    raise(1'b0, 5'd8, 32'h0, 32'h0000_0800, 2'd1);
    chk("R7", "ecall from S level", {30'b0, cap_priv}, 32'd3);
    chk("R7", "ecall from S cause", mcause_out, 32'd9);
    chk("R4", "status after ecall S", status_out, 32'h0000_0900);
    raise(1'b0, 5'd8, 32'h0, 32'h0000_0900, 2'd0);
    chk("R7", "ecall from U level", {30'b0, cap_priv}, 32'd1);
    chk("R7", "ecall from U cause", scause_out, 32'd8);
    chk("R3", "status after ecall U", status_out, 32'h0000_0800);
    raise(1'b0, 5'd8, 32'h0, 32'h0000_0A00, 2'd3);
    chk("R7", "ecall from M cause", mcause_out, 32'd11);
  endtask

  task automatic t_m_vector_tval;
    cfg_write(3'd4, 32'h0000_1001);
    raise(1'b1, 5'd7, 32'hCCCC_0000, 32'h0000_0B00, 2'd3);
    chk("R5", "M vectored async", cap_pc, 32'h0000_101C);
    raise(1'b0, 5'd4, 32'hCCCC_0004, 32'h0000_0B04, 2'd3);
    chk("R5", "M vectored sync no offset", cap_pc, 32'h0000_1000);
    chk("R6", "mtval misaligned", mtval_out, 32'hCCCC_0004);
    raise(1'b0, 5'd21, 32'hCCCC_0021, 32'h0000_0B08, 2'd3);
    chk("R6", "mtval guest fault", mtval_out, 32'hCCCC_0021);
    raise(1'b0, 5'd3, 32'hCCCC_0003, 32'h0000_0B0C, 2'd3);
    chk("R6", "mtval breakpoint", mtval_out, 32'h0);
  endtask

  task automatic t_idle;
    logic [31:0] st, me, se;
    st = status_out; me = mepc_out; se = sepc_out;
    @(negedge clk);
    trap_cause = 5'd13; trap_pc = 32'hFFFF_0000; cur_priv = 2'd0;
    cfg_sel = 3'd0; cfg_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "resv_clear idle", {31'b0, resv_clear}, 32'h0);
    chk("R9", "status holds", status_out, st);
    chk("R9", "mepc holds", mepc_out, me);
    chk("R9", "sepc holds", sepc_out, se);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_setup();
    t_sync_to_s();
    t_async_to_s();
    t_mask_split();
    t_from_m();
    t_ecall();
    t_m_vector_tval();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule